// File: doc/BRIEF.md
# Receive Packet Buffer with Commit and Rollback

This block holds the payload of incoming OUT data packets for one full-speed endpoint. The protocol engine pushes each received byte with a write strobe. The block cannot know whether the packet is good until the last byte is in. It therefore stores bytes under a speculative write pointer that only the writer sees. An end-of-packet strobe then carries the CRC verdict and the packet's data toggle, and the block either publishes the packet to the reader or rewinds so that the packet leaves no trace.

The reader sees a first-word-fall-through port. Data is valid whenever the empty flag is low, and a read strobe advances to the next byte. The writer sees a full flag, a free-space count and a room flag. The room flag tells the engine, before a packet begins, whether a maximum-size packet is sure to fit, so that it can refuse the packet early instead of overflowing partway through.

The block keeps an expected data toggle. A packet that arrives with the toggle of the packet last committed is a retransmission whose handshake was lost. The block drops it but still reports it as acceptable, so that the host gets its acknowledgement.

Top module: `pkt_rx_fifo`

## Requirements
- R1: After reset, `empty`=1, `full`=0, `free_space`=128, `room_ok`=1 and `ack`=0. The expected toggle is DATA0, encoded as `pkt_tgl`=0.
- R2: Each accepted write lowers `free_space` by one. Written bytes stay invisible to the reader, so `empty` stays 1 until a commit.
- R3: At a `pkt_end` with `crc_bad`=0, no overflow, and `pkt_tgl` equal to the expected toggle, the packet is committed. `ack` is 1 in the single cycle after `pkt_end`, the expected toggle flips, and the bytes are read out in write order.
- R4: At a `pkt_end` with `crc_bad`=1, the packet's bytes are dropped and `free_space` returns to its value before the packet. `ack` stays 0 and the expected toggle is unchanged.
- R5: At a `pkt_end` with `crc_bad`=0 and `pkt_tgl` different from the expected toggle, the packet is dropped as a duplicate, yet `ack` is 1 in the next cycle.
- R6: `full`=1 when 128 bytes, committed or not, have not yet been read. A write while full is ignored and marks an overflow. The next `pkt_end` then drops the packet with `ack`=0, and the overflow mark is cleared for the following packet.
- R7: `room_ok`=1 exactly when `free_space` is at least 64.
- R8: A read strobe while `empty`=1 is ignored: `free_space` and `empty` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for one payload byte |
| wr_data | input | 8 | Payload byte |
| pkt_end | input | 1 | End-of-packet strobe; the verdict is sampled with it |
| crc_bad | input | 1 | Shared CRC error indication for the packet just ended |
| pkt_tgl | input | 1 | Data toggle of the packet just ended (0 = DATA0) |
| rd_en | input | 1 | Read strobe; advances past the current byte |
| rd_data | output | 8 | Byte at the head of the committed data |
| empty | output | 1 | No committed byte is waiting |
| full | output | 1 | No space for another written byte |
| free_space | output | 8 | Bytes still writable |
| room_ok | output | 1 | A maximum-size packet fits |
| ack | output | 1 | Previous packet is to be acknowledged |

## Verification
The bench walks a run of packets that mixes good, corrupt and repeated toggles. These expose a design that publishes bytes before commit: the reader would see a non-empty buffer early. They also expose a design that flips the toggle on a rejected packet, which would drop the next good packet as a duplicate. A half-written packet ended with a bad CRC must give back all its space; a rewind to the wrong pointer would leak capacity. The bench fills the buffer exactly and writes one byte too many. A design that wraps would corrupt committed data, and a design that forgets the overflow would acknowledge a truncated packet. The room flag is checked on both sides of the 64-byte boundary, and reads while empty must not move the read pointer.

// File: rtl/pkt_rx_fifo.sv
module pkt_rx_fifo #(
  parameter int DW      = 8,
  parameter int DEPTH   = 128,
  parameter int MAX_PKT = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [DW-1:0]              wr_data,
  input  logic                       pkt_end,
  input  logic                       crc_bad,
  input  logic                       pkt_tgl,
  input  logic                       rd_en,
  output logic [DW-1:0]              rd_data,
  output logic                       empty,
  output logic                       full,
  output logic [$clog2(DEPTH):0]     free_space,
  output logic                       room_ok,
  output logic                       ack
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] DEPTH_P = (AW+1)'(DEPTH);
  localparam logic [AW:0] MAX_P   = (AW+1)'(MAX_PKT);

  logic [DW-1:0] mem [DEPTH];
  logic [AW:0]   wp_spec, wp_com, rp;
  logic          exp_tgl, ovf;
  logic [AW:0]   used;
  logic          wr_ok, accept, commit;

  assign used       = wp_spec - rp;
  assign full       = (used == DEPTH_P);
  assign free_space = DEPTH_P - used;
  assign room_ok    = (free_space >= MAX_P);
  assign empty      = (rp == wp_com);
  assign rd_data    = mem[rp[AW-1:0]];
  assign wr_ok      = wr_en && !full;
  assign accept     = !crc_bad && !ovf;
  assign commit     = pkt_end && accept && (pkt_tgl == exp_tgl);

  always_ff @(posedge clk)
    if (wr_ok) mem[wp_spec[AW-1:0]] <= wr_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp_spec <= '0;
      wp_com  <= '0;
      rp      <= '0;
      exp_tgl <= 1'b0;
      ovf     <= 1'b0;
      ack     <= 1'b0;
    end else begin
      if (rd_en && !empty) rp <= rp + 1'b1;
      if (pkt_end) begin
        ack <= accept;
        ovf <= 1'b0;
        if (commit) begin
          wp_com  <= wp_spec;
          exp_tgl <= ~exp_tgl;
        end else begin
          wp_spec <= wp_com;
        end
      end else begin
        ack <= 1'b0;
        if (wr_ok) wp_spec <= wp_spec + 1'b1;
        if (wr_en && full) ovf <= 1'b1;
      end
    end
  end

  // R2
  hidden_until_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !pkt_end) |=> empty);
  // R6
  full_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_en && !rd_en && !pkt_end) |=> full);
  // R4
  bad_crc_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_end && crc_bad) |=> !ack);
  // R3
  ack_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pkt_end |=> !ack);
  // R8
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && rd_en && !wr_en && !pkt_end) |=> $stable(free_space));
  // R7
  free_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    free_space <= DEPTH_P);
endmodule

// File: tb/tb_pkt_rx_fifo.sv
module tb_pkt_rx_fifo;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, pkt_end = 0, crc_bad = 0, pkt_tgl = 0, rd_en = 0;
  logic [7:0] wr_data = 0, rd_data, free_space;
  logic empty, full, room_ok, ack;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  pkt_rx_fifo dut (.clk, .rst_n, .wr_en, .wr_data, .pkt_end, .crc_bad, .pkt_tgl,
    .rd_en, .rd_data, .empty, .full, .free_space, .room_ok, .ack);

  // {len[7:0], tgl, bad, exp_ack, exp_store, 4'b0}
  localparam logic [15:0] VEC [7] = '{
    {8'd5,  1'b0, 1'b0, 1'b1, 1'b1, 4'h0},
    {8'd5,  1'b0, 1'b0, 1'b1, 1'b0, 4'h0},
    {8'd7,  1'b1, 1'b1, 1'b0, 1'b0, 4'h0},
    {8'd7,  1'b1, 1'b0, 1'b1, 1'b1, 4'h0},
    {8'd1,  1'b0, 1'b0, 1'b1, 1'b1, 4'h0},
    {8'd64, 1'b1, 1'b0, 1'b1, 1'b1, 4'h0},
    {8'd3,  1'b1, 1'b0, 1'b1, 1'b0, 4'h0}
  };

  task automatic tick; @(negedge clk); endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int k, input int i);
    return 8'(k * 37 + i);
  endfunction

  task automatic write_bytes(input int k, input int n);
    for (int i = 0; i < n; i++) begin
      wr_en = 1; wr_data = pat(k, i); tick;
    end
    wr_en = 0;
  endtask

  task automatic end_pkt(input logic t, input logic bad);
    pkt_end = 1; pkt_tgl = t; crc_bad = bad; tick;
    pkt_end = 0; crc_bad = 0;
  endtask

  task automatic drain(input int k, input int n, input string req);
    for (int i = 0; i < n; i++) begin
      chk(!empty && rd_data == pat(k, i), req, rd_data, pat(k, i));
      rd_en = 1; tick; rd_en = 0;
    end
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tick; tick; rst_n = 1; tick;
    // R1
    chk(empty && !full && free_space == 128 && room_ok && !ack, "R1", {empty, full, room_ok, ack}, 4'b1010);

    foreach (VEC[v]) begin
      int len; logic t, bad, ea, es;
      {len, t, bad, ea, es} = {VEC[v][15:8], VEC[v][7], VEC[v][6], VEC[v][5], VEC[v][4]};
      write_bytes(v, len);
      chk(empty, "R2", empty, 1);
      chk(free_space == 8'(128 - len), "R2", free_space, 128 - len);
      end_pkt(t, bad);
      // R3 R4 R5
      chk(ack == ea, bad ? "R4" : (es ? "R3" : "R5"), ack, ea);
      tick;
      chk(!ack, "R3", ack, 0);
      if (es) drain(v, len, "R3");
      chk(empty && free_space == 128, es ? "R3" : (bad ? "R4" : "R5"), free_space, 128);
    end

    // R4: partial packet rolled back, toggle kept (next DATA0 still commits)
    write_bytes(20, 3);
    chk(free_space == 125 && empty, "R2", free_space, 125);
    end_pkt(1'b0, 1'b1);
    chk(!ack && free_space == 128, "R4", free_space, 128);
    tick;

    write_bytes(21, 64);
    end_pkt(1'b0, 1'b0);
    chk(ack && !empty, "R4", ack, 1);
    chk(free_space == 64 && room_ok, "R7", room_ok, 1);

    // R6: fill, then overflow
    write_bytes(22, 64);
    chk(full && free_space == 0 && !room_ok, "R6", free_space, 0);
    write_bytes(23, 1);
    chk(full && free_space == 0, "R6", free_space, 0);
    end_pkt(1'b1, 1'b0);
    chk(!ack && free_space == 64, "R6", ack, 0);
    tick;
    write_bytes(24, 1);
    end_pkt(1'b1, 1'b0);
    chk(ack, "R6", ack, 1);
    chk(free_space == 63 && !room_ok, "R7", room_ok, 0);
    drain(21, 64, "R6");
    drain(24, 1, "R6");
    chk(empty && free_space == 128, "R6", free_space, 128);

    // R8
    rd_en = 1; tick; tick; rd_en = 0;
    chk(empty && free_space == 128, "R8", free_space, 128);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule